// File: doc/BRIEF.md
# Fixed-Window Channel Buffer and Sequencer

This block holds the recent history of received channel samples for a soft-output trellis decoder that works on fixed windows. Every enabled cycle it takes in one quantised systematic sample, one parity sample and one a-priori sample, and it packs them into a single word. It serves that history to three consumers at once. The forward unit gets the oldest words in arrival order. The two reverse units get words in reverse order: one sweeps the newest complete block to find a starting point, and the other sweeps the block before it while its results are written to metric storage.

All addressing comes from one master counter that wraps through the whole buffer. Its upper bits choose which block plays which part, and its lower bits give the position inside a block. The two reverse units swap roles at every block boundary, and the block keeps write enables for them to match. The block also keeps a stream position counter for the input side and a copy of it delayed by the full decoding latency for the output side. A frame-start pulse clears the upper part of the input counter, and the output counter repeats that clear when the frame start reaches the output.

Top module: `winbuf_sequencer`

## Requirements
- R1: The stored word is `{in_apr, in_par, in_sys}` (systematic in bits 3:0, parity in 7:4, a-priori in 11:8). Once 64 enabled cycles have passed, `fwd_word` equals the word written 64 enabled cycles earlier. It is read from the address about to be overwritten.
- R2: The search-mode word is taken from block (n-1) mod 4, where n is the current write block, at offset 15-`fwd_pos`. So it returns the previous period's words in descending order.
- R3: The store-mode word is taken from block (n-2) mod 4 at offset 15-`fwd_pos`, in descending order.
- R4: The master counter advances by one each enabled cycle and wraps from 63 to 0. `wr_blk` and `fwd_blk` are its upper 2 bits, and `fwd_pos` is its lower 4 bits. `srch_blk` is `wr_blk`-1 mod 4, `stor_blk` is `wr_blk`-2 mod 4, and `rev_pos` is 15-`fwd_pos`.
- R5: `unit_a_search` is 1 after reset and flips at the end of every 16th enabled cycle. `unit_a_word` carries the search-mode word when it is 1 and the store-mode word when it is 0. `unit_b_word` carries the other one.
- R6: While `en` is high, exactly one write enable is high: `unit_b_wren` when unit A is in search mode, and `unit_a_wren` otherwise.
- R7: `in_bitcnt` is `{upper10, master counter}`. The upper field increases by one when the master counter wraps.
- R8: `out_valid` rises once 65 enabled cycles have passed since reset. From then on, `out_bitcnt` equals the value `in_bitcnt` had 65 enabled cycles earlier. Before that, it is 0.
- R9: While `en` is low, no word is written, both write enables are low, and no counter or role changes.
- R10: A `sync` with `en` high clears the upper field of `in_bitcnt` at that edge, and this takes priority over the wrap increment. A `sync` with `en` low has no effect.
- R11: Reset is synchronous. It clears every counter and `out_valid`, and it puts unit A in search mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance / write enable |
| sync | input | 1 | Frame-start pulse |
| in_sys | input | 4 | Systematic sample, sign-magnitude |
| in_par | input | 4 | Parity sample, sign-magnitude |
| in_apr | input | 4 | A-priori sample, sign-magnitude |
| fwd_word | output | 12 | Word for the forward unit |
| fwd_blk | output | 2 | Block read by the forward unit |
| fwd_pos | output | 4 | Ascending position in the block (forward metric read address) |
| unit_a_word | output | 12 | Word routed to reverse unit A |
| unit_b_word | output | 12 | Word routed to reverse unit B |
| unit_a_search | output | 1 | 1 when unit A is in search mode |
| unit_a_wren | output | 1 | Metric write enable for unit A |
| unit_b_wren | output | 1 | Metric write enable for unit B |
| rev_pos | output | 4 | Descending position (metric write address) |
| wr_blk | output | 2 | Block being written |
| srch_blk | output | 2 | Block swept in search mode |
| stor_blk | output | 2 | Block swept in store mode |
| in_bitcnt | output | 16 | Input stream position |
| out_bitcnt | output | 16 | Output stream position |
| out_valid | output | 1 | Output counter meaningful |

## Verification
Read words, pointers, positions, the role flag and the write enables are combinational from state, so their new values are due right after the clock edge that advanced the counter. The bench samples 1 ns after each rising edge and compares against a model indexed by the number of enabled edges since reset. A forward word is due exactly 64 enabled edges after it was written. A search-mode word is due in the period after it was written and a store-mode word two periods after. The output counter is checked against the input history 65 enabled edges back. Paused cycles do not advance the model's index, so any write or step that happens during a pause shows up as a mismatch later.

// File: rtl/winbuf_pkg.sv
package winbuf_pkg;
   // read-port indices of the channel store
   typedef enum int {
      PORT_FWD  = 0,
      PORT_SRCH = 1,
      PORT_STOR = 2
   } rd_port_e;

   localparam int NUM_RD_PORTS = 3;

   // block distances behind the write block, by role
   localparam int FWD_BACK  = 0;   // oldest content, read before overwrite
   localparam int SRCH_BACK = 1;   // newest complete block
   localparam int STOR_BACK = 2;   // block before that

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/winbuf_store.sv
module winbuf_store #(
   parameter int WORD_W = 12,
   parameter int ADDR_W = 6,
   parameter int NRD    = 3
) (
   input  logic                         clk,
   input  logic                         we,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [WORD_W-1:0]            wr_data,
   input  logic [NRD-1:0][ADDR_W-1:0]   rd_addr,
   output logic [NRD-1:0][WORD_W-1:0]   rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [WORD_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem_q[wr_addr] <= wr_data;
      end
   end

   // asynchronous reads: each port sees the contents before this cycle's write
   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rd_data[g] = mem_q[rd_addr[g]];
   end
endmodule

// File: rtl/winbuf_counter.sv
module winbuf_counter #(
   parameter int BLK_W = 2,
   parameter int OFF_W = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   output logic [BLK_W+OFF_W-1:0]   cnt,
   output logic [BLK_W-1:0]         wr_blk,
   output logic [BLK_W-1:0]         fwd_blk,
   output logic [BLK_W-1:0]         srch_blk,
   output logic [BLK_W-1:0]         stor_blk,
   output logic [OFF_W-1:0]         off,
   output logic [OFF_W-1:0]         rev_off,
   output logic                     a_search,
   output logic                     a_wren,
   output logic                     b_wren
);
   import winbuf_pkg::*;

   localparam int ADDR_W = BLK_W + OFF_W;

   logic [ADDR_W-1:0] cnt_q;
   logic              a_srch_q;
   logic              period_last;

   assign period_last = &cnt_q[OFF_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q    <= '0;
         a_srch_q <= 1'b1;
      end else if (en) begin
         cnt_q <= cnt_q + ADDR_W'(1);
         if (period_last) begin
            a_srch_q <= ~a_srch_q;
         end
      end
   end

   assign cnt      = cnt_q;
   assign wr_blk   = cnt_q[ADDR_W-1:OFF_W];
   assign off      = cnt_q[OFF_W-1:0];
   assign rev_off  = ~cnt_q[OFF_W-1:0];
   assign fwd_blk  = wr_blk - BLK_W'(FWD_BACK);
   assign srch_blk = wr_blk - BLK_W'(SRCH_BACK);
   assign stor_blk = wr_blk - BLK_W'(STOR_BACK);

   // the unit in store mode writes metrics every enabled cycle
   assign a_search = a_srch_q;
   assign a_wren   = en & ~a_srch_q;
   assign b_wren   = en &  a_srch_q;
endmodule

// File: rtl/winbuf_tally.sv
module winbuf_tally #(
   parameter int CNT_W   = 16,
   parameter int LOW_W   = 6,
   parameter int LATENCY = 65
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             sync,
   input  logic [LOW_W-1:0] low,
   output logic [CNT_W-1:0] in_cnt,
   output logic [CNT_W-1:0] out_cnt,
   output logic             out_valid
);
   localparam int HI_W = CNT_W - LOW_W;
   localparam int PW   = $clog2(LATENCY + 1);

   logic [HI_W-1:0]    in_hi_q;
   logic [HI_W-1:0]    out_hi_q;
   logic [LATENCY-1:0] sync_dly_q;
   logic [PW-1:0]      prime_q;
   logic               primed;
   logic [LOW_W-1:0]   out_low;

   assign primed  = (prime_q == PW'(LATENCY));
   // the lag is a whole buffer plus the remainder, so the low field trails by the remainder
   assign out_low = low - LOW_W'(LATENCY);

   always_ff @(posedge clk) begin
      if (rst) begin
         in_hi_q    <= '0;
         out_hi_q   <= '0;
         sync_dly_q <= '0;
         prime_q    <= '0;
      end else if (en) begin
         sync_dly_q <= {sync_dly_q[LATENCY-2:0], sync};
         if (sync) begin
            in_hi_q <= '0;
         end else if (&low) begin
            in_hi_q <= in_hi_q + HI_W'(1);
         end
         if (!primed) begin
            prime_q <= prime_q + PW'(1);
         end else if (sync_dly_q[LATENCY-1]) begin
            out_hi_q <= '0;
         end else if (&out_low) begin
            out_hi_q <= out_hi_q + HI_W'(1);
         end
      end
   end

   assign in_cnt    = {in_hi_q, low};
   assign out_cnt   = primed ? {out_hi_q, out_low} : '0;
   assign out_valid = primed;
endmodule

// File: rtl/winbuf_sequencer.sv
module winbuf_sequencer #(
   parameter int SAMPLE_W    = 4,
   parameter int BLK_DEPTH   = 16,
   parameter int NUM_BLKS    = 4,
   parameter int CNT_W       = 16,
   parameter int PIPE_STAGES = 1
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      en,
   input  logic                      sync,
   input  logic [SAMPLE_W-1:0]       in_sys,
   input  logic [SAMPLE_W-1:0]       in_par,
   input  logic [SAMPLE_W-1:0]       in_apr,
   output logic [3*SAMPLE_W-1:0]     fwd_word,
   output logic [$clog2(NUM_BLKS)-1:0]  fwd_blk,
   output logic [$clog2(BLK_DEPTH)-1:0] fwd_pos,
   output logic [3*SAMPLE_W-1:0]     unit_a_word,
   output logic [3*SAMPLE_W-1:0]     unit_b_word,
   output logic                      unit_a_search,
   output logic                      unit_a_wren,
   output logic                      unit_b_wren,
   output logic [$clog2(BLK_DEPTH)-1:0] rev_pos,
   output logic [$clog2(NUM_BLKS)-1:0]  wr_blk,
   output logic [$clog2(NUM_BLKS)-1:0]  srch_blk,
   output logic [$clog2(NUM_BLKS)-1:0]  stor_blk,
   output logic [CNT_W-1:0]          in_bitcnt,
   output logic [CNT_W-1:0]          out_bitcnt,
   output logic                      out_valid
);
   import winbuf_pkg::*;

   localparam int WORD_W  = 3 * SAMPLE_W;
   localparam int OFF_W   = $clog2(BLK_DEPTH);
   localparam int BLK_W   = $clog2(NUM_BLKS);
   localparam int ADDR_W  = OFF_W + BLK_W;
   localparam int DEPTH   = BLK_DEPTH * NUM_BLKS;
   localparam int LATENCY = DEPTH + PIPE_STAGES;

   // elaboration-time parameter checks
   if (!is_pow2(BLK_DEPTH) || BLK_DEPTH < 2) begin : g_bad_depth
      $error("BLK_DEPTH must be a power of two, at least 2");
   end
   if (!is_pow2(NUM_BLKS) || NUM_BLKS < 4) begin : g_bad_blks
      $error("NUM_BLKS must be a power of two, at least 4");
   end
   if (CNT_W <= ADDR_W) begin : g_bad_cnt
      $error("CNT_W must exceed the buffer address width");
   end
   if (PIPE_STAGES < 1 || PIPE_STAGES >= DEPTH) begin : g_bad_pipe
      $error("PIPE_STAGES out of range");
   end
   if (SAMPLE_W < 2) begin : g_bad_sample
      $error("SAMPLE_W must hold a sign and a magnitude");
   end

   logic [ADDR_W-1:0]                     cnt;
   logic [OFF_W-1:0]                      rev_off;
   logic                                  a_srch;
   logic [NUM_RD_PORTS-1:0][ADDR_W-1:0]   rd_addr;
   logic [NUM_RD_PORTS-1:0][WORD_W-1:0]   rd_data;
   logic [WORD_W-1:0]                     wr_word;

   winbuf_counter #(
      .BLK_W (BLK_W),
      .OFF_W (OFF_W)
   ) u_counter (
      .clk      (clk),
      .rst      (rst),
      .en       (en),
      .cnt      (cnt),
      .wr_blk   (wr_blk),
      .fwd_blk  (fwd_blk),
      .srch_blk (srch_blk),
      .stor_blk (stor_blk),
      .off      (fwd_pos),
      .rev_off  (rev_off),
      .a_search (a_srch),
      .a_wren   (unit_a_wren),
      .b_wren   (unit_b_wren)
   );

   assign wr_word = {in_apr, in_par, in_sys};

   assign rd_addr[PORT_FWD]  = {fwd_blk, fwd_pos};
   assign rd_addr[PORT_SRCH] = {srch_blk, rev_off};
   assign rd_addr[PORT_STOR] = {stor_blk, rev_off};

   winbuf_store #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W),
      .NRD    (NUM_RD_PORTS)
   ) u_store (
      .clk     (clk),
      .we      (en & ~rst),
      .wr_addr (cnt),
      .wr_data (wr_word),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   winbuf_tally #(
      .CNT_W   (CNT_W),
      .LOW_W   (ADDR_W),
      .LATENCY (LATENCY)
   ) u_tally (
      .clk       (clk),
      .rst       (rst),
      .en        (en),
      .sync      (sync),
      .low       (cnt),
      .in_cnt    (in_bitcnt),
      .out_cnt   (out_bitcnt),
      .out_valid (out_valid)
   );

   assign fwd_word      = rd_data[PORT_FWD];
   assign rev_pos       = rev_off;
   assign unit_a_search = a_srch;
   assign unit_a_word   = a_srch ? rd_data[PORT_SRCH] : rd_data[PORT_STOR];
   assign unit_b_word   = a_srch ? rd_data[PORT_STOR] : rd_data[PORT_SRCH];
endmodule

// File: rtl/winbuf_checker.sv
module winbuf_checker #(
   parameter int CNT_W = 16,
   parameter int LOW_W = 6,
   parameter int OFF_W = 4,
   parameter int BLK_W = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic             sync,
   input logic [BLK_W-1:0] wr_blk,
   input logic [OFF_W-1:0] fwd_pos,
   input logic             unit_a_search,
   input logic             unit_a_wren,
   input logic             unit_b_wren,
   input logic [CNT_W-1:0] in_bitcnt,
   input logic [CNT_W-1:0] out_bitcnt,
   input logic             out_valid
);
   localparam int AW = BLK_W + OFF_W;

   assert_step_R4: assert property (@(posedge clk) disable iff (rst)
      en |=> ({wr_blk, fwd_pos} == ($past({wr_blk, fwd_pos}) + AW'(1))));

   assert_role_flip_R5: assert property (@(posedge clk) disable iff (rst)
      (en && (&fwd_pos)) |=> (unit_a_search != $past(unit_a_search)));

   assert_one_writer_R6: assert property (@(posedge clk) disable iff (rst)
      en |-> ($countones({unit_a_wren, unit_b_wren}) == 1));

   assert_in_step_R7: assert property (@(posedge clk) disable iff (rst)
      (en && !sync && !(&in_bitcnt[LOW_W-1:0])) |=>
      (in_bitcnt == ($past(in_bitcnt) + CNT_W'(1))));

   assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> out_valid);

   assert_pause_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !en |=> ($stable(in_bitcnt) && $stable(out_bitcnt) && $stable(unit_a_search)));

   assert_pause_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
      !en |-> !(unit_a_wren || unit_b_wren));

   assert_sync_clear_R10: assert property (@(posedge clk) disable iff (rst)
      (en && sync) |=> (in_bitcnt[CNT_W-1:LOW_W] == '0));

   assert_reset_R11: assert property (@(posedge clk)
      rst |=> ((in_bitcnt == '0) && unit_a_search && !out_valid));
endmodule

bind winbuf_sequencer winbuf_checker #(
   .CNT_W (CNT_W),
   .LOW_W (ADDR_W),
   .OFF_W (OFF_W),
   .BLK_W (BLK_W)
) u_checker (
   .clk           (clk),
   .rst           (rst),
   .en            (en),
   .sync          (sync),
   .wr_blk        (wr_blk),
   .fwd_pos       (fwd_pos),
   .unit_a_search (unit_a_search),
   .unit_a_wren   (unit_a_wren),
   .unit_b_wren   (unit_b_wren),
   .in_bitcnt     (in_bitcnt),
   .out_bitcnt    (out_bitcnt),
   .out_valid     (out_valid)
);

// File: tb/winbuf_sequencer_bench.sv
`timescale 1ns/1ps
module winbuf_sequencer_bench;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0;
   logic sync = 1'b0;
   logic [3:0] in_sys = '0, in_par = '0, in_apr = '0;
   logic [11:0] fwd_word, unit_a_word, unit_b_word;
   logic [1:0]  fwd_blk, wr_blk, srch_blk, stor_blk;
   logic [3:0]  fwd_pos, rev_pos;
   logic        unit_a_search, unit_a_wren, unit_b_wren, out_valid;
   logic [15:0] in_bitcnt, out_bitcnt;

   always #2.5 clk = ~clk;

   winbuf_sequencer u_winbuf_sequencer (
      .clk(clk), .rst(rst), .en(en), .sync(sync),
      .in_sys(in_sys), .in_par(in_par), .in_apr(in_apr),
      .fwd_word(fwd_word), .fwd_blk(fwd_blk), .fwd_pos(fwd_pos),
      .unit_a_word(unit_a_word), .unit_b_word(unit_b_word),
      .unit_a_search(unit_a_search), .unit_a_wren(unit_a_wren), .unit_b_wren(unit_b_wren),
      .rev_pos(rev_pos), .wr_blk(wr_blk), .srch_blk(srch_blk), .stor_blk(stor_blk),
      .in_bitcnt(in_bitcnt), .out_bitcnt(out_bitcnt), .out_valid(out_valid)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;
   int k = 0;
   logic [9:0]  hi_m = '0;
   logic [11:0] whist [0:4095];
   logic [15:0] ihist [0:4095];

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s at step %0d: got %0h expected %0h", tag, k, got, exp);
      end
   endtask

   task automatic check_all(input logic e);
      int p, off, n, s;
      logic a_exp;
      logic [11:0] srch_w, stor_w;
      p = k / 16; off = k % 16; n = p % 4;
      chk("R4 wr_blk", 32'(wr_blk), 32'(n));
      chk("R4 fwd_blk", 32'(fwd_blk), 32'(n));
      chk("R4 srch_blk", 32'(srch_blk), 32'((n + 3) % 4));
      chk("R4 stor_blk", 32'(stor_blk), 32'((n + 2) % 4));
      chk("R4 fwd_pos", 32'(fwd_pos), 32'(off));
      chk("R4 rev_pos", 32'(rev_pos), 32'(15 - off));
      a_exp = (p % 2 == 0);
      chk("R5 role", 32'(unit_a_search), 32'(a_exp));
      chk("R6 a_wren", 32'(unit_a_wren), 32'(e && !a_exp));
      chk("R6 b_wren", 32'(unit_b_wren), 32'(e && a_exp));
      if (k >= 64) chk("R1 forward word", 32'(fwd_word), 32'(whist[k - 64]));
      srch_w = a_exp ? unit_a_word : unit_b_word;
      stor_w = a_exp ? unit_b_word : unit_a_word;
      if (p >= 1) begin
         s = 16 * (p - 1) + (15 - off);
         chk("R2 search word", 32'(srch_w), 32'(whist[s]));
      end
      if (p >= 2) begin
         s = 16 * (p - 2) + (15 - off);
         chk("R3 store word", 32'(stor_w), 32'(whist[s]));
      end
      chk("R7 in_bitcnt", 32'(in_bitcnt), 32'(ihist[k]));
      chk("R8 out_valid", 32'(out_valid), 32'(k >= 65));
      chk("R8 out_bitcnt", 32'(out_bitcnt), (k >= 65) ? 32'(ihist[k - 65]) : 32'h0);
   endtask

   task automatic do_step(input logic e, input logic s);
      logic [11:0] w;
      @(negedge clk);
      w = 12'((k * 37) + ((k >> 4) * 5) + 3);
      if (!e) w = ~w;
      en = e; sync = s;
      in_sys = w[3:0]; in_par = w[7:4]; in_apr = w[11:8];
      @(posedge clk); #1;
      if (e) begin
         whist[k] = w;
         if (s) hi_m = '0;            // R10 sync wins over wrap
         else if (k % 64 == 63) hi_m = hi_m + 10'd1;
         k++;
         ihist[k] = {hi_m, 6'(k % 64)};
      end
      check_all(e);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; en = 1'b1; sync = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      k = 0; hi_m = '0; ihist[0] = '0;
      @(negedge clk);
      rst = 1'b0; en = 1'b0; sync = 1'b0;
      #1;
      chk("R11 reset in_bitcnt", 32'(in_bitcnt), 32'h0);
      chk("R11 reset out_bitcnt", 32'(out_bitcnt), 32'h0);
      chk("R11 reset out_valid", 32'(out_valid), 32'h0);
      chk("R11 reset role", 32'(unit_a_search), 32'h1);
      chk("R11 reset wr_blk", 32'(wr_blk), 32'h0);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      ihist[0] = '0;
      do_reset();
      for (int i = 0; i < 1500; i++) begin
         logic e, s;
         e = !((i % 97) == 50 || (i % 97) == 51 || (i % 97) == 52);
         // R10: i==51 is a sync during a pause and must be ignored
         s = (i == 51) || (i == 300) || (i == 820) ||
             (i > 1000 && i < 1200 && (k % 64) == 63 && (i % 2) == 0);
         do_step(e, s);
      end
      do_reset();
      for (int i = 0; i < 200; i++) begin
         do_step(!((i % 31) == 7), i == 90);
      end
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule